// File: doc/BRIEF.md
# Chainable Serial Loader for an 18-Channel Reference Register Bank

This block receives 16-bit command words over a three-wire serial link (serial clock, serial data, active-low frame enable) and keeps a bank of 18 ten-bit channel registers that downstream logic reads directly. Every bit received is also passed on, through a serial output that changes on falling serial-clock edges. Several devices can therefore be chained on one host port: the serial output of one drives the serial input of the next, while the clock and the enable are shared.

The three serial inputs are asynchronous to the block's system clock. They are brought into that clock domain through synchronizer stages, and their edges are detected there. When the enable rises, the last 16 bits received are decoded into a test bit, a channel address and a value. If the word is well formed, the value is written to the addressed channel and that channel's update strobe pulses for one system-clock cycle. In a chain of m devices the host shifts 16·m bits during one enable-low window. Each device keeps the last 16 bits that reached it, and all devices commit on the same enable rising edge.

Top module: `refbank_serial_top`

## Requirements
- R1: While en_n is low, each rising sclk edge shifts sdi into a 16-bit shift register, most significant bit first.
- R2: A word is decoded as bit 15 = test bit (must be 0), bits 14..10 = channel address (binary, 0 to 17), bits 9..0 = channel value.
- R3: On a rising edge of en_n, a valid word writes its value into the addressed channel's register, visible on chan_val.
- R4: While en_n is high, sclk edges are ignored: the shift register and sdo do not change.
- R5: sdo changes only on falling sclk edges while en_n is low, and shows the bit that entered on sdi 16 rising edges earlier. A frame longer than 16 bits leaves the last 16 bits in the device.
- R6: If fewer than 16 rising sclk edges occur between the fall and the rise of en_n, no register is written.
- R7: A word with bit 15 set, or with an address above 17, writes no register.
- R8: A synchronous active-high rst clears all channel registers, the shift register, sdo and every strobe.
- R9: Each commit pulses exactly one bit of upd_strobe, the bit of the written channel, for one clk cycle. No channel value changes without its strobe.
- R10: sclk, sdi and en_n are synchronized to clk, so each of their levels must be held for at least three clk cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sdi | input | 1 | Serial data in |
| en_n | input | 1 | Active-low frame enable; its rising edge commits the word |
| sdo | output | 1 | Serial data out for chaining, changes on falling sclk |
| chan_val | output | N_CH x 10 | Packed channel registers, channel i at index i |
| upd_strobe | output | N_CH | One-cycle strobe for each channel written |

## Verification
The bench builds the block with its default parameters: 18 channels and two synchronizer stages. With these values the decode boundary sits exactly between address 17, which is written, and addresses 18 to 31, which are ignored. The bench drives both sides of that boundary, along with the extreme values 0 and 1023 and a test-bit word. It checks sdo at every falling sclk edge against a serial model that carries bits across frames. This makes a 32-bit chained frame, a short frame and clock toggles during enable-high observable at the ports.

// File: rtl/refbank_pkg.sv
package refbank_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 10;
    localparam int WORD_W = 1 + ADDR_W + DATA_W;

    typedef struct packed {
        logic              test;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } sync_sig_t;

    function automatic cmd_t decode_word(input logic [WORD_W-1:0] w);
        return cmd_t'(w);
    endfunction
endpackage

// File: rtl/refbank_sync.sv
module refbank_sync
    import refbank_pkg::*;
#(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    output sync_sig_t sig
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= {(STAGES+1){RST_VAL}};
        else     pipe <= {pipe[STAGES-1:0], din};
    end

    always_comb begin
        sig.level = pipe[STAGES-1];
        sig.rise  = pipe[STAGES-1] & ~pipe[STAGES];
        sig.fall  = ~pipe[STAGES-1] & pipe[STAGES];
    end
endmodule

// File: rtl/refbank_shifter.sv
module refbank_shifter
    import refbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sync_sig_t         sclk_s,
    input  sync_sig_t         en_s,
    input  logic              sdi_s,
    output logic [WORD_W-1:0] word,
    output logic              full,
    output logic              sdo
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [CNT_W-1:0] cnt;
    logic             active;

    assign active = ~en_s.level;

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            cnt  <= '0;
            sdo  <= 1'b0;
        end else begin
            if (en_s.fall) begin
                cnt <= '0;
            end else if (active && sclk_s.rise) begin
                word <= {word[WORD_W-2:0], sdi_s};
                if (cnt != CNT_W'(WORD_W)) cnt <= cnt + 1'b1;
            end
            if (active && sclk_s.fall) sdo <= word[WORD_W-1];
        end
    end

    assign full = (cnt == CNT_W'(WORD_W));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(WORD_W)); // R6
    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(active && sclk_s.fall) |=> $stable(sdo)); // R4
    AST_WORD_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        en_s.level |=> $stable(word)); // R4
endmodule

// File: rtl/refbank_bank.sv
module refbank_bank
    import refbank_pkg::*;
#(
    parameter int N_CH = 18
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         commit,
    input  logic                         full,
    input  cmd_t                         cmd,
    output logic [N_CH-1:0][DATA_W-1:0]  vals,
    output logic [N_CH-1:0]              strobe
);
    logic accept;

    assign accept = commit && full && !cmd.test && (int'(cmd.addr) < N_CH);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic wr;
        assign wr = accept && (int'(cmd.addr) == i);

        always_ff @(posedge clk) begin
            if (rst) begin
                vals[i]   <= '0;
                strobe[i] <= 1'b0;
            end else begin
                strobe[i] <= wr;
                if (wr) vals[i] <= cmd.data;
            end
        end

        AST_NO_SILENT_WRITE: assert property (@(posedge clk) disable iff (rst)
            (vals[i] != $past(vals[i])) |-> strobe[i]); // R9
    end

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe)); // R9
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (|strobe) |=> !(|strobe)); // R9
endmodule

// File: rtl/refbank_serial_top.sv
module refbank_serial_top
    import refbank_pkg::*;
#(
    parameter int N_CH        = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sclk,
    input  logic                         sdi,
    input  logic                         en_n,
    output logic                         sdo,
    output logic [N_CH-1:0][DATA_W-1:0]  chan_val,
    output logic [N_CH-1:0]              upd_strobe
);
    sync_sig_t         sclk_s, en_s, sdi_s;
    logic [WORD_W-1:0] word;
    logic              full;
    cmd_t              cmd;

    refbank_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst(rst), .din(sclk), .sig(sclk_s));
    refbank_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_en (
        .clk(clk), .rst(rst), .din(en_n), .sig(en_s));
    refbank_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
        .clk(clk), .rst(rst), .din(sdi), .sig(sdi_s));

    refbank_shifter u_shift (
        .clk(clk), .rst(rst), .sclk_s(sclk_s), .en_s(en_s), .sdi_s(sdi_s.level),
        .word(word), .full(full), .sdo(sdo));

    assign cmd = decode_word(word);

    refbank_bank #(.N_CH(N_CH)) u_bank (
        .clk(clk), .rst(rst), .commit(en_s.rise), .full(full), .cmd(cmd),
        .vals(chan_val), .strobe(upd_strobe));

    AST_STROBE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (|upd_strobe) |-> $past(en_s.rise)); // R3
    AST_STROBE_VALID_ADDR: assert property (@(posedge clk) disable iff (rst)
        (|upd_strobe) |-> ($past(int'(cmd.addr)) < N_CH && !$past(cmd.test))); // R7
endmodule

// File: tb/sim_refbank_serial_top.sv
module sim_refbank_serial_top;
    localparam int CLK_P = 10;
    localparam int HP    = 8;
    localparam int NCH   = 18;

    logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, sdi = 1'b0, en_n = 1'b1;
    logic sdo;
    logic [NCH-1:0][9:0] chan_val;
    logic [NCH-1:0]      upd_strobe;

    int checks = 0, fails = 0;
    logic [15:0] ser_model = '0;
    logic [9:0]  bank_model [NCH];
    typedef struct { int ch; logic [9:0] val; } exp_t;
    exp_t q[$];

    refbank_serial_top u0 (.clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .en_n(en_n),
        .sdo(sdo), .chan_val(chan_val), .upd_strobe(upd_strobe));

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic ok, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: every strobe must match the next queued commit (R3, R9)
    always @(negedge clk) begin
        if (!rst && (|upd_strobe)) begin
            if (q.size() == 0) begin
                chk("R9", 1'b0, "unexpected strobe", int'(upd_strobe), 0);
            end else begin
                exp_t e;
                logic [NCH-1:0] oh;
                e = q.pop_front();
                oh = '0;
                oh[e.ch] = 1'b1;
                chk("R9", upd_strobe == oh, "strobe pattern", int'(upd_strobe), int'(oh));
                chk("R3", chan_val[e.ch] == e.val, "written value", int'(chan_val[e.ch]), int'(e.val));
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_bank(input string req);
        logic ok = 1'b1;
        for (int i = 0; i < NCH; i++) if (chan_val[i] != bank_model[i]) ok = 1'b0;
        chk(req, ok, "bank contents", int'(chan_val[0]), int'(bank_model[0]));
    endtask

    // Driver: shift n bits MSB first, checking sdo at every falling edge (R1, R5)
    task automatic frame(input logic [63:0] bits, input int n, input string req);
        logic [15:0] w;
        sclk = 1'b0;
        wait_clk(HP);
        en_n = 1'b0;
        wait_clk(HP);
        for (int k = 1; k <= n; k++) begin
            sdi = bits[n-k];
            wait_clk(HP);
            sclk = 1'b1;
            ser_model = {ser_model[14:0], bits[n-k]};
            wait_clk(HP);
            sclk = 1'b0;
            wait_clk(HP);
            chk("R5", sdo == ser_model[15], "sdo bit", int'(sdo), int'(ser_model[15]));
        end
        w = bits[15:0];
        // R2 / R6 / R7: decode expectation
        if (n >= 16 && !w[15] && int'(w[14:10]) < NCH) begin
            q.push_back('{int'(w[14:10]), w[9:0]});
            bank_model[int'(w[14:10])] = w[9:0];
        end
        en_n = 1'b1;
        wait_clk(4 * HP);
        check_bank(req);
        chk(req, q.size() == 0, "pending commits", q.size(), 0);
    endtask

    function automatic logic [15:0] mk(input logic t, input int a, input int v);
        return {t, 5'(a), 10'(v)};
    endfunction

    initial begin
        for (int i = 0; i < NCH; i++) bank_model[i] = '0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // R8: reset state
        chk("R8", sdo == 1'b0, "sdo after reset", int'(sdo), 0);
        chk("R8", upd_strobe == '0, "strobe after reset", int'(upd_strobe), 0);
        check_bank("R8");

        frame(64'(mk(0, 0, 1023)), 16, "R3");
        frame(64'(mk(0, 17, 31)), 16, "R2");
        frame(64'(mk(0, 2, 513)), 16, "R1");
        frame(64'(mk(0, 7, 31)), 16, "R3");
        frame(64'(mk(0, 0, 512)), 16, "R3");
        frame(64'(mk(0, 18, 77)), 16, "R7");
        frame(64'(mk(0, 31, 1000)), 16, "R7");
        frame(64'(mk(1, 3, 400)), 16, "R7");
        frame(64'(mk(0, 4, 300)) >> 6, 10, "R6");
        // Chain: 32 bits, device keeps the last word (R5)
        frame({32'b0, mk(0, 9, 111), mk(0, 5, 222)}, 32, "R5");

        // R4: sclk toggles with en_n high must not shift
        begin
            logic sdo_before;
            sdo_before = sdo;
            sdi = 1'b1;
            for (int k = 0; k < 5; k++) begin
                wait_clk(HP); sclk = 1'b1; wait_clk(HP); sclk = 1'b0;
            end
            wait_clk(HP);
            chk("R4", sdo == sdo_before, "sdo with enable high", int'(sdo), int'(sdo_before));
            check_bank("R4");
        end
        frame(64'(mk(0, 12, 0)), 16, "R4");
        frame(64'(mk(0, 17, 1023)), 16, "R10");

        wait_clk(20);
        chk("R9", q.size() == 0, "drained queue", q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule